// File: doc/BRIEF.md
# Dual-Strobe Burst Address Generator

This block is the address front end of a synchronous burst memory. Each clock edge it decides, from two active-low address strobes and three chip enables, whether to start a new burst from the external address, end the current cycle as a deselect, or carry on with the burst already running. A burst is four beats long. The upper address bits are held for the whole burst, and the low two bits step through either a linear or an interleaved order.

The processor strobe is gated by the first chip enable, and a burst it starts is always a read. The controller strobe is not gated. A burst it starts is a write when the write request is high, and a read otherwise. Once a burst is running, both strobes are high. The advance input then either steps to the next beat or stretches the current beat as a wait cycle. In these continuing cycles the cycle type follows the write request, so a write is possible on the cycle after a processor-strobe read. The memory array and the data path belong to the surrounding logic.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high, and on the first edge after it, `addr_out` is 0, `cycle_active` is 0 and `cycle_kind` is 0. The `cycle_kind` encoding is 0 none, 1 read, 2 write.
- R2: If `strb_proc_n`=0 and the device is selected (`ce_a_n`=0, `ce_b`=1, `ce_c_n`=0), the next `addr_out` equals `addr_in`, `cycle_active` is 1 and `cycle_kind` is 1, whatever the value of `wr_req`. This case takes priority over the controller strobe.
- R3: If `strb_ctrl_n`=0, the device is selected and R2 does not apply, the next `addr_out` equals `addr_in`, `cycle_active` is 1 and `cycle_kind` is 2 when `wr_req`=1, or 1 when `wr_req`=0.
- R4: While `ce_a_n`=1, a low `strb_proc_n` with `strb_ctrl_n`=1 has no effect. The cycle continues or waits exactly as if both strobes were high.
- R5: `strb_ctrl_n`=0 with `ce_a_n`=1 is a deselect. The next `cycle_active` is 0, `cycle_kind` is 0 and `addr_out` is held.
- R6: In a cycle where a strobe takes effect, `ce_b`=0 or `ce_c_n`=1 causes a deselect. In a cycle where no strobe takes effect, these two enables are ignored.
- R7: With `order_ilv`=0 at load, beat k (k = 0..3) puts (start + k) mod 4 on the low two address bits.
- R8: With `order_ilv`=1 at load, beat k puts start XOR k on the low two address bits. The order is sampled only when a burst loads, so changing `order_ilv` mid-burst has no effect.
- R9: With both strobes inactive and a burst running, `adv_n`=0 steps to the next beat, and `adv_n`=1 holds `addr_out` unchanged.
- R10: The upper address bits stay constant during a burst. After the fourth beat, the low bits return to the start value.
- R11: While no burst is running, `adv_n` is ignored. `addr_out` holds and `cycle_active` stays 0 until a strobe with a valid selection arrives.
- R12: In a continuing or waiting cycle of a running burst, `cycle_kind` is 2 when `wr_req`=1 and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | External address captured at burst start |
| strb_proc_n | input | 1 | Processor address strobe, active low, gated by `ce_a_n` |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_a_n | input | 1 | Chip enable A, active low |
| ce_b | input | 1 | Chip enable B, active high |
| ce_c_n | input | 1 | Chip enable C, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| wr_req | input | 1 | Write request, the decoded result of the byte-write controls |
| addr_out | output | ADDR_W | Internal burst address |
| cycle_active | output | 1 | A burst cycle is in progress |
| cycle_kind | output | 2 | 0 none, 1 read, 2 write |

## Verification
A wrong beat counter or a wrong stored start value shows up at once as a wrong low address. It appears on the edge after the bad step and comes back on every later beat, including the wrap to the start value after the fourth beat. A wrong decode of the strobes and enables shows on the next edge in one of three ways: `cycle_active` drops when it should not, the address is reloaded when it should not be, or the address steps through a deselect. A liveness flag left set after a deselect shows one edge later, when an advance moves the address even though no burst is running.

// File: rtl/bag_pkg.sv
package bag_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        CYC_NONE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_t;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_LOAD_PROC,
        ACT_LOAD_CTRL,
        ACT_DESELECT,
        ACT_STEP,
        ACT_WAIT
    } ctl_act_t;

    typedef struct packed {
        logic strb_proc_n;
        logic strb_ctrl_n;
        logic adv_n;
        logic ce_a_n;
        logic ce_b;
        logic ce_c_n;
    } ctl_in_t;

    function automatic logic is_load(ctl_act_t a);
        return (a == ACT_LOAD_PROC) || (a == ACT_LOAD_CTRL);
    endfunction
endpackage

// File: rtl/bag_sel_decode.sv
module bag_sel_decode
    import bag_pkg::*;
(
    input  ctl_in_t  ctl,
    input  logic     burst_live,
    output ctl_act_t act
);
    logic selected;
    logic proc_hit;

    assign selected = !ctl.ce_a_n && ctl.ce_b && !ctl.ce_c_n;
    // The processor strobe only counts when enable A is active.
    assign proc_hit = !ctl.strb_proc_n && !ctl.ce_a_n;

    always_comb begin
        if (proc_hit) begin
            act = selected ? ACT_LOAD_PROC : ACT_DESELECT;
        end else if (!ctl.strb_ctrl_n) begin
            act = selected ? ACT_LOAD_CTRL : ACT_DESELECT;
        end else if (!burst_live) begin
            act = ACT_IDLE;
        end else if (!ctl.adv_n) begin
            act = ACT_STEP;
        end else begin
            act = ACT_WAIT;
        end
    end
endmodule

// File: rtl/bag_burst_seq.sv
module bag_burst_seq
    import bag_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_act_t          act,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              order_ilv,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int UP_W = ADDR_W - BEAT_W;

    logic [UP_W-1:0]   upper_q;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_q;
    logic              ilv_q;
    logic [BEAT_W-1:0] lin_sum;
    logic [BEAT_W-1:0] low_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            start_q <= '0;
            beat_q  <= '0;
            ilv_q   <= 1'b0;
        end else if (is_load(act)) begin
            upper_q <= addr_in[ADDR_W-1:BEAT_W];
            start_q <= addr_in[BEAT_W-1:0];
            beat_q  <= '0;
            ilv_q   <= order_ilv;
        end else if (act == ACT_STEP) begin
            beat_q  <= beat_q + 1'b1;
        end
    end

    // The sum wraps modulo 2**BEAT_W, which gives the linear order.
    assign lin_sum = start_q + beat_q;

    for (genvar i = 0; i < BEAT_W; i++) begin : g_low
        assign low_bits[i] = ilv_q ? (start_q[i] ^ beat_q[i]) : lin_sum[i];
    end

    assign addr_out = {upper_q, low_bits};
endmodule

// File: rtl/bag_cycle_track.sv
module bag_cycle_track
    import bag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctl_act_t  act,
    input  logic      wr_req,
    output logic      live,
    output cyc_kind_t kind
);
    cyc_kind_t req_kind;
    assign req_kind = wr_req ? CYC_WRITE : CYC_READ;

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= 1'b0;
            kind <= CYC_NONE;
        end else begin
            unique case (act)
                ACT_LOAD_PROC: begin
                    live <= 1'b1;
                    kind <= CYC_READ;
                end
                ACT_LOAD_CTRL: begin
                    live <= 1'b1;
                    kind <= req_kind;
                end
                ACT_DESELECT: begin
                    live <= 1'b0;
                    kind <= CYC_NONE;
                end
                ACT_STEP, ACT_WAIT: begin
                    kind <= req_kind;
                end
                default: begin
                    live <= live;
                    kind <= kind;
                end
            endcase
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strb_proc_n,
    input  logic              strb_ctrl_n,
    input  logic              adv_n,
    input  logic              ce_a_n,
    input  logic              ce_b,
    input  logic              ce_c_n,
    input  logic              order_ilv,
    input  logic              wr_req,
    output logic [ADDR_W-1:0] addr_out,
    output logic              cycle_active,
    output logic [1:0]        cycle_kind
);
    ctl_in_t   ctl;
    ctl_act_t  act;
    logic      live;
    cyc_kind_t kind;

    assign ctl = '{strb_proc_n: strb_proc_n, strb_ctrl_n: strb_ctrl_n,
                   adv_n: adv_n, ce_a_n: ce_a_n, ce_b: ce_b, ce_c_n: ce_c_n};

    bag_sel_decode u_dec (
        .ctl        (ctl),
        .burst_live (live),
        .act        (act)
    );

    bag_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .addr_in   (addr_in),
        .order_ilv (order_ilv),
        .addr_out  (addr_out)
    );

    bag_cycle_track u_trk (
        .clk    (clk),
        .rst    (rst),
        .act    (act),
        .wr_req (wr_req),
        .live   (live),
        .kind   (kind)
    );

    assign cycle_active = live;
    assign cycle_kind   = kind;
endmodule

// File: rtl/bag_checker.sv
module bag_checker
    import bag_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strb_proc_n,
    input logic              strb_ctrl_n,
    input logic              adv_n,
    input logic              ce_a_n,
    input logic              ce_b,
    input logic              ce_c_n,
    input logic [ADDR_W-1:0] addr_out,
    input logic              cycle_active,
    input logic [1:0]        cycle_kind
);
    logic no_strobe;
    assign no_strobe = strb_ctrl_n && (strb_proc_n || ce_a_n);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!cycle_active && cycle_kind == 2'd0 && addr_out == '0));

    assert_proc_load_read_R2: assert property (@(posedge clk) disable iff (rst)
        (!strb_proc_n && !ce_a_n && ce_b && !ce_c_n)
        |=> (cycle_active && cycle_kind == 2'd1 && addr_out == $past(addr_in)));

    assert_ctrl_masked_deselect_R5: assert property (@(posedge clk) disable iff (rst)
        (!strb_ctrl_n && ce_a_n) |=> (!cycle_active && cycle_kind == 2'd0));

    assert_bad_enable_deselect_R6: assert property (@(posedge clk) disable iff (rst)
        ((!strb_ctrl_n || (!strb_proc_n && !ce_a_n)) && (!ce_b || ce_c_n))
        |=> !cycle_active);

    assert_wait_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (cycle_active && adv_n && no_strobe) |=> $stable(addr_out));

    assert_upper_fixed_R10: assert property (@(posedge clk) disable iff (rst)
        no_strobe |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    assert_idle_ignores_adv_R11: assert property (@(posedge clk) disable iff (rst)
        (!cycle_active && no_strobe) |=> (!cycle_active && $stable(addr_out)));
endmodule

bind burst_addr_gen bag_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .addr_in      (addr_in),
    .strb_proc_n  (strb_proc_n),
    .strb_ctrl_n  (strb_ctrl_n),
    .adv_n        (adv_n),
    .ce_a_n       (ce_a_n),
    .ce_b         (ce_b),
    .ce_c_n       (ce_c_n),
    .addr_out     (addr_out),
    .cycle_active (cycle_active),
    .cycle_kind   (cycle_kind)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
    localparam int AW = 18;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic strb_proc_n = 1'b1, strb_ctrl_n = 1'b1, adv_n = 1'b1;
    logic ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
    logic order_ilv = 1'b0, wr_req = 1'b0;
    logic [AW-1:0] addr_out;
    logic cycle_active;
    logic [1:0] cycle_kind;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .order_ilv(order_ilv), .wr_req(wr_req),
        .addr_out(addr_out), .cycle_active(cycle_active), .cycle_kind(cycle_kind)
    );

    task automatic check(input bit ok, input string tag, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply inputs, let one rising edge take them, then sample after the edge.
    task automatic step(input logic p, input logic c, input logic adv,
                        input logic [2:0] ce, input logic wr, input logic ord,
                        input logic [AW-1:0] a);
        strb_proc_n = p; strb_ctrl_n = c; adv_n = adv;
        ce_a_n = ce[2]; ce_b = ce[1]; ce_c_n = ce[0];
        wr_req = wr; order_ilv = ord; addr_in = a;
        @(posedge clk);
        #1;
    endtask

    localparam logic [2:0] SEL = 3'b010;

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(addr_out == '0, "R1 addr", addr_out, '0);
        check(!cycle_active && cycle_kind == 2'd0, "R1 active/kind",
              {cycle_active, cycle_kind}, '0);
        rst = 1'b0;

        // R11: idle, advance ignored
        step(1, 1, 0, SEL, 0, 0, 18'h3FFFF);
        check(!cycle_active && addr_out == '0, "R11 idle adv",
              {cycle_active, addr_out}, '0);

        // Burst sweep over start value, order, strobe and write request.
        for (int st = 0; st < 4; st++)
        for (int ord = 0; ord < 2; ord++)
        for (int src = 0; src < 2; src++)
        for (int wr = 0; wr < 2; wr++) begin
            logic [AW-3:0] up;
            logic [AW-1:0] exp;
            logic [1:0] exp_low;
            logic [1:0] exp_kind;
            up = (AW-2)'(st*37 + ord*5 + src*3 + wr + 1);
            if (src == 0) step(0, 1, 1, SEL, wr[0], ord[0], {up, st[1:0]});
            else          step(1, 0, 1, SEL, wr[0], ord[0], {up, st[1:0]});
            exp_kind = (src == 0) ? 2'd1 : (wr != 0 ? 2'd2 : 2'd1);
            check(addr_out == {up, st[1:0]} && cycle_active,
                  src == 0 ? "R2 load addr" : "R3 load addr", addr_out, {up, st[1:0]});
            check(cycle_kind == exp_kind, src == 0 ? "R2 kind" : "R3 kind",
                  AW'(cycle_kind), AW'(exp_kind));
            for (int k = 1; k <= 4; k++) begin
                // Flip the order pin mid-burst: it must not matter (R8).
                step(1, 1, 0, SEL, wr[0], ~ord[0], '0);
                exp_low = (ord != 0) ? (st[1:0] ^ 2'(k)) : 2'(st + k);
                exp = {up, exp_low};
                check(addr_out == exp, ord != 0 ? "R8 interleave beat" : "R7 linear beat",
                      addr_out, exp);
                check(cycle_kind == (wr != 0 ? 2'd2 : 2'd1), "R12 continue kind",
                      AW'(cycle_kind), AW'(wr != 0 ? 2 : 1));
                if (k == 4)
                    check(addr_out == {up, st[1:0]}, "R10 wrap", addr_out, {up, st[1:0]});
            end
            exp = addr_out;
            step(1, 1, 1, SEL, 0, ord[0], '1);
            check(addr_out == exp && cycle_active, "R9 wait hold", addr_out, exp);
        end

        // Decode sweep: every enable combination against every strobe pattern.
        for (int ce = 0; ce < 8; ce++)
        for (int pc = 0; pc < 4; pc++) begin
            logic [AW-1:0] base, nxt, exp_a, exp_b;
            logic pn, cn, sel, a_n, exp_act, load, desel;
            logic [1:0] exp_k;
            string tag;
            base = {16'h0055, 2'b01};
            nxt  = {16'h00AA, 2'b10};
            step(1, 0, 1, SEL, 0, 0, base);
            pn = (pc == 0 || pc == 2) ? 1'b0 : 1'b1;
            cn = (pc == 1 || pc == 2) ? 1'b0 : 1'b1;
            a_n = ce[2];
            sel = !ce[2] && ce[1] && !ce[0];
            load = 0; desel = 0; exp_k = 2'd2;
            tag = "R6 ignored";
            if (!pn && !a_n) begin
                if (sel) begin load = 1; exp_k = 2'd1; tag = "R2"; end
                else begin desel = 1; tag = "R6"; end
            end else if (!cn) begin
                if (sel) begin load = 1; exp_k = 2'd2; tag = "R3"; end
                else begin desel = 1; tag = a_n ? "R5" : "R6"; end
            end else if (!pn) begin
                tag = "R4";
            end
            step(pn, cn, 0, 3'(ce), 1, 0, nxt);
            exp_act = !desel;
            exp_a = load ? nxt : (desel ? base : {16'h0055, 2'b10});
            if (desel) exp_k = 2'd0;
            check(cycle_active == exp_act && cycle_kind == exp_k,
                  {tag, " decode"}, AW'({cycle_active, cycle_kind}), AW'({exp_act, exp_k}));
            check(addr_out == exp_a, {tag, " addr"}, addr_out, exp_a);
            step(1, 1, 0, SEL, 0, 0, '1);
            exp_b = desel ? base : {exp_a[AW-1:2], 2'(exp_a[1:0] + 1)};
            check(cycle_active == exp_act && addr_out == exp_b,
                  desel ? "R11 after deselect" : "R9 step after decode",
                  addr_out, exp_b);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule